// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries a 16-bit processor into and out of an interrupt handler. It watches a non-maskable request line and a maskable request line with its type number. At an instruction boundary it picks the winning request and saves the flags word, the code segment and the instruction pointer on the memory stack. It clears the interrupt-enable bit in one uninterrupted sequence with those pushes, reads the handler's offset and segment from the vector table at the bottom of memory, and hands the new context to the register file in a single load pulse.

A return command runs the reverse sequence. It pops the instruction pointer, then the code segment, then the flags word, and loads them back together with the restored stack pointer. All memory traffic uses one word-wide request/acknowledge port with 20-bit byte addresses. Register values come in on plain input buses and leave on a load strobe with its data.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `mem_req` and `ctx_ld` are all 0.
- R2: An interrupt request is accepted only in a cycle where `insn_done` is 1. With `insn_done` held at 0 the block stays idle.
- R3: A pending non-maskable request wins over a maskable one and is serviced with type number 2, whatever the interrupt-enable bit holds.
- R4: A maskable request is taken only while bit 9 of `flags_in` (the interrupt-enable bit) is 1. With that bit at 0 it is ignored: `busy` stays 0 and no memory access occurs.
- R5: Entry writes three words in this order: flags, CS, IP. Before each write the stack pointer drops by 2, and the write address is (SS*16 + SP) mod 2^20.
- R6: After the pushes the block reads the offset word at byte address type*4 and then the segment word at type*4+2.
- R7: At the end of entry `ctx_ld` pulses for exactly one cycle. At that point `ctx_ip` holds the offset, `ctx_cs` the segment, `ctx_sp` the incoming SP minus 6, and `ctx_flags` the saved flags with bit 9 cleared.
- R8: `busy` is 1 from the cycle after acceptance through the `ctx_ld` cycle. A non-maskable pulse that arrives while busy stays pending and is serviced at the next boundary.
- R9: A `ret_cmd` pulse while idle reads IP, CS and flags from SS:SP, SS:SP+2 and SS:SP+4. It then loads them with `ctx_sp` = SP+6, so the enable bit returns to its saved value.
- R10: While `mem_req` is 1 and `mem_ack` is 0, the address, write enable and write data do not change.
- R11: The non-maskable input is edge sensitive. A level held high across several boundaries is serviced once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request, rising edge latched |
| intr_req | input | 1 | Maskable request, level |
| intr_type | input | 8 | Type number of the maskable request |
| insn_done | input | 1 | Current instruction has completed |
| ret_cmd | input | 1 | Start the return sequence |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete in this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| ctx_ld | output | 1 | One-cycle load strobe for the new context |
| ctx_flags | output | 16 | Flags value to load |
| ctx_cs | output | 16 | CS value to load |
| ctx_ip | output | 16 | IP value to load |
| ctx_sp | output | 16 | SP value to load |

## Verification
The entry path is driven with a maskable request alone, with both requests at once, with a non-maskable request while the enable bit is clear, and with a maskable request while the enable bit is clear. These cases separate the priority rule from the masking rule. The stack cases put SP at zero and place SS near the top of memory, so both the 16-bit pointer wrap and the 20-bit address wrap show up in the pushed addresses. Vector types 0, 2 and FFh reach both ends of the table. Directed runs cover a pulse arriving mid-sequence, a held level, and a return that must restore the saved enable bit.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_F, S_PUSH_CS, S_PUSH_IP, S_VEC_LO, S_VEC_HI,
    S_POP_IP, S_POP_CS, S_POP_F, S_LOAD
  } seq_state_e;

  // segment:offset to a 20-bit physical byte address, carry out dropped
  function automatic logic [19:0] stack_addr(input logic [15:0] seg,
                                             input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // table entry of a type: offset word first, segment word two bytes above
  function automatic logic [19:0] vec_addr(input logic [7:0] vtype,
                                           input logic seg_word);
    return {10'd0, vtype, seg_word, 1'b0};
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter logic [7:0] NMI_TYPE = 8'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_req,
  input  logic       intr_req,
  input  logic [7:0] intr_type,
  input  logic       if_flag,
  input  logic       grant,
  output logic       req_valid,
  output logic [7:0] req_type,
  output logic       req_is_nmi
);
  logic nmi_q, nmi_pend;
  logic nmi_rise, mask_ok;

  assign nmi_rise = nmi_req & ~nmi_q;
  assign mask_ok  = intr_req & if_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_req;
      if (nmi_rise)
        nmi_pend <= 1'b1;
      else if (grant && nmi_pend)
        nmi_pend <= 1'b0;
    end
  end

  assign req_is_nmi = nmi_pend;
  assign req_valid  = nmi_pend | mask_ok;
  assign req_type   = nmi_pend ? NMI_TYPE : intr_type;

  // R4: a maskable grant only happens with the enable bit set
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !req_is_nmi |-> if_flag);

  // R11: a serviced pulse is consumed unless a fresh edge arrives
  p_nmi_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_is_nmi && !nmi_rise |=> !nmi_pend);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int IF_BIT = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_done,
  input  logic        ret_cmd,
  input  logic        req_valid,
  input  logic [7:0]  req_type,
  input  logic [15:0] flags_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] ss_in,
  output logic        grant,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        ctx_ld,
  output logic [15:0] ctx_flags,
  output logic [15:0] ctx_cs,
  output logic [15:0] ctx_ip,
  output logic [15:0] ctx_sp
);
  seq_state_e  state;
  logic [15:0] flags_w, cs_w, ip_w, sp_w, ss_w;
  logic [7:0]  type_w;
  logic        entry_w;
  logic [15:0] sp_dec, sp_inc;
  logic        start_ret, start_irq;

  assign sp_dec    = sp_w - 16'd2;
  assign sp_inc    = sp_w + 16'd2;
  assign start_ret = (state == S_IDLE) && ret_cmd;
  assign start_irq = (state == S_IDLE) && !ret_cmd && insn_done && req_valid;
  assign grant     = start_irq;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_F:  begin mem_we = 1'b1; mem_addr = stack_addr(ss_w, sp_dec); mem_wdata = flags_w; end
      S_PUSH_CS: begin mem_we = 1'b1; mem_addr = stack_addr(ss_w, sp_dec); mem_wdata = cs_w; end
      S_PUSH_IP: begin mem_we = 1'b1; mem_addr = stack_addr(ss_w, sp_dec); mem_wdata = ip_w; end
      S_VEC_LO:  mem_addr = vec_addr(type_w, 1'b0);
      S_VEC_HI:  mem_addr = vec_addr(type_w, 1'b1);
      S_POP_IP, S_POP_CS, S_POP_F: mem_addr = stack_addr(ss_w, sp_w);
      default:   mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      flags_w <= '0;
      cs_w    <= '0;
      ip_w    <= '0;
      sp_w    <= '0;
      ss_w    <= '0;
      type_w  <= '0;
      entry_w <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start_ret) begin
            sp_w    <= sp_in;
            ss_w    <= ss_in;
            entry_w <= 1'b0;
            state   <= S_POP_IP;
          end else if (start_irq) begin
            flags_w <= flags_in;
            cs_w    <= cs_in;
            ip_w    <= ip_in;
            sp_w    <= sp_in;
            ss_w    <= ss_in;
            type_w  <= req_type;
            entry_w <= 1'b1;
            state   <= S_PUSH_F;
          end
        end
        S_PUSH_F: if (mem_ack) begin
          sp_w            <= sp_dec;
          flags_w[IF_BIT] <= 1'b0;
          state           <= S_PUSH_CS;
        end
        S_PUSH_CS: if (mem_ack) begin sp_w <= sp_dec; state <= S_PUSH_IP; end
        S_PUSH_IP: if (mem_ack) begin sp_w <= sp_dec; state <= S_VEC_LO; end
        S_VEC_LO:  if (mem_ack) begin ip_w <= mem_rdata; state <= S_VEC_HI; end
        S_VEC_HI:  if (mem_ack) begin cs_w <= mem_rdata; state <= S_LOAD; end
        S_POP_IP:  if (mem_ack) begin ip_w <= mem_rdata; sp_w <= sp_inc; state <= S_POP_CS; end
        S_POP_CS:  if (mem_ack) begin cs_w <= mem_rdata; sp_w <= sp_inc; state <= S_POP_F; end
        S_POP_F:   if (mem_ack) begin flags_w <= mem_rdata; sp_w <= sp_inc; state <= S_LOAD; end
        S_LOAD:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign ctx_ld    = (state == S_LOAD);
  assign ctx_flags = flags_w;
  assign ctx_cs    = cs_w;
  assign ctx_ip    = ip_w;
  assign ctx_sp    = sp_w;

  // R10: an access in flight keeps its address, direction and data
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7: load strobe lasts one cycle
  p_ld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_ld |=> !ctx_ld);

  // R7: entry always hands over a cleared enable bit
  p_if_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_ld && entry_w |-> !ctx_flags[IF_BIT]);

  // R2: a sequence that is not a return starts only at a boundary
  p_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(ret_cmd) |-> $past(insn_done));

  // R8: busy ends only after the load cycle
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ctx_ld));

  // R5: every completed push lowers the stack pointer by one word
  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> sp_w == $past(sp_w) - 16'd2);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int         IF_BIT   = 9,
  parameter logic [7:0] NMI_TYPE = 8'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        intr_req,
  input  logic [7:0]  intr_type,
  input  logic        insn_done,
  input  logic        ret_cmd,
  input  logic [15:0] flags_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] ss_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        ctx_ld,
  output logic [15:0] ctx_flags,
  output logic [15:0] ctx_cs,
  output logic [15:0] ctx_ip,
  output logic [15:0] ctx_sp
);
  logic       grant, req_valid, req_is_nmi;
  logic [7:0] req_type;

  irq_arbiter #(.NMI_TYPE(NMI_TYPE)) u_arb (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .intr_req(intr_req),
    .intr_type(intr_type), .if_flag(flags_in[IF_BIT]), .grant(grant),
    .req_valid(req_valid), .req_type(req_type), .req_is_nmi(req_is_nmi)
  );

  irq_seq_fsm #(.IF_BIT(IF_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .ret_cmd(ret_cmd),
    .req_valid(req_valid), .req_type(req_type),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .ss_in(ss_in),
    .grant(grant), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ctx_ld(ctx_ld), .ctx_flags(ctx_flags), .ctx_cs(ctx_cs), .ctx_ip(ctx_ip), .ctx_sp(ctx_sp)
  );

  // R3: a pending non-maskable request is the one granted
  p_nmi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_is_nmi |-> req_type == NMI_TYPE);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0, intr_req = 1'b0, insn_done = 1'b0, ret_cmd = 1'b0;
  logic [7:0]  intr_type = '0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, sp_in = '0, ss_in = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, ctx_ld;
  logic [15:0] ctx_flags, ctx_cs, ctx_ip, ctx_sp;

  always #2.5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .intr_req(intr_req),
    .intr_type(intr_type), .insn_done(insn_done), .ret_cmd(ret_cmd),
    .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .ss_in(ss_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .ctx_ld(ctx_ld),
    .ctx_flags(ctx_flags), .ctx_cs(ctx_cs), .ctx_ip(ctx_ip), .ctx_sp(ctx_sp)
  );

  // memory model: 8 KB window, one wait cycle per access, trace of completed accesses
  logic [15:0] mem_m [0:4095];
  int          tr_n;
  logic [19:0] tr_a [0:15];
  logic        tr_w [0:15];
  logic [15:0] tr_d [0:15];

  always_comb mem_rdata = mem_m[mem_addr[12:1]];

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && mem_ack) begin
        if (mem_we) mem_m[mem_addr[12:1]] = mem_wdata;
        if (tr_n < 16) begin
          tr_a[tr_n] = mem_addr;
          tr_w[tr_n] = mem_we;
          tr_d[tr_n] = mem_we ? mem_wdata : mem_rdata;
          tr_n = tr_n + 1;
        end
      end
      mem_ack <= mem_req && !mem_ack;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] off_of(input int t);  return {8'hA5, t[7:0]}; endfunction
  function automatic logic [15:0] seg_of(input int t);  return {t[7:0], 8'h3C}; endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    int v;
    v = (int'(s) * 16 + int'(o)) % 1048576;
    return v[19:0];
  endfunction

  typedef struct packed {
    logic        use_nmi;
    logic        use_intr;
    logic [7:0]  itype;
    logic [15:0] flags;
    logic [15:0] cs;
    logic [15:0] ip;
    logic [15:0] sp;
    logic [15:0] ss;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b1, 8'h21, 16'h0200, 16'h1234, 16'h5678, 16'h0800, 16'h0100},
    '{1'b0, 1'b1, 8'h08, 16'h0000, 16'h1111, 16'h2222, 16'h0900, 16'h0100},
    '{1'b1, 1'b1, 8'h40, 16'h0203, 16'hABCD, 16'h0010, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 8'h00, 16'h0000, 16'h0F00, 16'h0100, 16'h0200, 16'hFFF0},
    '{1'b0, 1'b1, 8'hFF, 16'h0ED5, 16'h0000, 16'hFFFE, 16'h1002, 16'h0050},
    '{1'b0, 1'b1, 8'h00, 16'hFFFF, 16'h7777, 16'h8888, 16'h0C00, 16'h0080}
  };

  task automatic wait_ld(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 80 && !seen; k++) begin
      @(negedge clk);
      if (ctx_ld) seen = 1'b1;
    end
  endtask

  task automatic pulse_boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic run_row(input row_t r);
    int t;
    bit taken, seen;
    logic [15:0] sp1, sp2, sp3;
    @(negedge clk);
    tr_n = 0;
    flags_in = r.flags; cs_in = r.cs; ip_in = r.ip; sp_in = r.sp; ss_in = r.ss;
    intr_type = r.itype; intr_req = r.use_intr; nmi_req = r.use_nmi;
    @(negedge clk) nmi_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 idle before boundary", {31'd0, busy}, 32'd0);
    taken = r.use_nmi || (r.use_intr && r.flags[9]);
    t = r.use_nmi ? 2 : int'(r.itype);
    pulse_boundary();
    if (!taken) begin
      repeat (10) @(negedge clk);
      chk("R4 masked request ignored: busy", {31'd0, busy}, 32'd0);
      chk("R4 masked request ignored: accesses", tr_n, 0);
      intr_req = 1'b0;
      return;
    end
    chk("R8 busy during entry", {31'd0, busy}, 32'd1);
    wait_ld(seen);
    intr_req = 1'b0;
    chk("R7 load strobe seen", {31'd0, seen}, 32'd1);
    sp1 = r.sp - 16'd2; sp2 = r.sp - 16'd4; sp3 = r.sp - 16'd6;
    chk("R5 access count", tr_n, 5);
    chk("R5 flags push addr", {12'd0, tr_a[0]}, {12'd0, phys(r.ss, sp1)});
    chk("R5 flags push data", {15'd0, tr_w[0], tr_d[0]}, {15'd0, 1'b1, r.flags});
    chk("R5 cs push addr", {12'd0, tr_a[1]}, {12'd0, phys(r.ss, sp2)});
    chk("R5 cs push data", {15'd0, tr_w[1], tr_d[1]}, {15'd0, 1'b1, r.cs});
    chk("R5 ip push addr", {12'd0, tr_a[2]}, {12'd0, phys(r.ss, sp3)});
    chk("R5 ip push data", {15'd0, tr_w[2], tr_d[2]}, {15'd0, 1'b1, r.ip});
    chk(r.use_nmi ? "R3 nmi vector offset addr" : "R6 vector offset addr",
        {11'd0, tr_w[3], tr_a[3]}, t * 4);
    chk("R6 vector segment addr", {11'd0, tr_w[4], tr_a[4]}, t * 4 + 2);
    chk("R7 new ip", {16'd0, ctx_ip}, {16'd0, off_of(t)});
    chk("R7 new cs", {16'd0, ctx_cs}, {16'd0, seg_of(t)});
    chk("R7 new sp", {16'd0, ctx_sp}, {16'd0, sp3});
    chk("R7 new flags", {16'd0, ctx_flags}, {16'd0, r.flags & 16'hFDFF});
    chk("R8 busy in load cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R7 strobe one cycle", {31'd0, ctx_ld}, 32'd0);
    chk("R8 busy released", {31'd0, busy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual cycles 150000 expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit seen;
    tr_n = 0;
    for (int i = 0; i < 4096; i++) mem_m[i] = 16'h0000;
    for (int t = 0; t < 256; t++) begin
      mem_m[t * 2]     = off_of(t);
      mem_m[t * 2 + 1] = seg_of(t);
    end
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 ctx_ld after reset", {31'd0, ctx_ld}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

    // R9: return from the entry made by row 0
    @(negedge clk);
    tr_n = 0;
    sp_in = 16'h07FA; ss_in = 16'h0100; flags_in = 16'h0000;
    ret_cmd = 1'b1;
    @(negedge clk) ret_cmd = 1'b0;
    wait_ld(seen);
    chk("R9 return strobe", {31'd0, seen}, 32'd1);
    chk("R9 pop count", tr_n, 3);
    chk("R9 ip pop addr", {12'd0, tr_a[0]}, {12'd0, phys(16'h0100, 16'h07FA)});
    chk("R9 flags pop addr", {12'd0, tr_a[2]}, {12'd0, phys(16'h0100, 16'h07FE)});
    chk("R9 restored ip", {16'd0, ctx_ip}, 32'h5678);
    chk("R9 restored cs", {16'd0, ctx_cs}, 32'h1234);
    chk("R9 restored flags with enable", {16'd0, ctx_flags}, 32'h0200);
    chk("R9 restored sp", {16'd0, ctx_sp}, 32'h0800);

    // R8: NMI pulse during a maskable entry stays pending
    @(negedge clk);
    flags_in = 16'h0200; cs_in = 16'h4000; ip_in = 16'h0040; sp_in = 16'h0A00; ss_in = 16'h0100;
    intr_type = 8'h10; intr_req = 1'b1;
    pulse_boundary();
    @(negedge clk) nmi_req = 1'b1;
    @(negedge clk) nmi_req = 1'b0;
    wait_ld(seen);
    intr_req = 1'b0;
    chk("R8 first entry is maskable", {16'd0, ctx_cs}, {16'd0, seg_of(16)});
    repeat (3) @(negedge clk);
    chk("R8 idle between entries", {31'd0, busy}, 32'd0);
    pulse_boundary();
    wait_ld(seen);
    chk("R8 pending nmi serviced", {16'd0, ctx_cs}, {16'd0, seg_of(2)});

    // R11: a held NMI level is serviced once
    repeat (3) @(negedge clk);
    nmi_req = 1'b1;
    repeat (2) @(negedge clk);
    pulse_boundary();
    wait_ld(seen);
    chk("R11 first entry on edge", {31'd0, seen}, 32'd1);
    repeat (3) @(negedge clk);
    tr_n = 0;
    pulse_boundary();
    repeat (10) @(negedge clk);
    chk("R11 held level not retaken", {31'd0, busy}, 32'd0);
    chk("R11 no accesses", tr_n, 0);
    nmi_req = 1'b0;

    // R2: a request with no boundary never starts
    @(negedge clk);
    flags_in = 16'h0200; intr_type = 8'h33; intr_req = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 no boundary no entry", {31'd0, busy}, 32'd0);
    intr_req = 1'b0;

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule